// File: doc/BRIEF.md
# Next Program Counter Unit

This block decides where a 32-bit, word-aligned RISC core fetches next. Each cycle it takes the address of the current instruction, the instruction word, a flag saying whether the two register operands compared equal, and the contents of the source register named by the instruction. It selects one of four candidate addresses: the following word, a branch target relative to the following word, a jump target inside the current 256 MB region, or the register value. One clock later it presents that address on a registered output.

For the call instruction, the unit also presents the return address and a write strobe on registered outputs. The register file uses these to store the return address in register 31. The register file, the comparator that produces the equality flag, and any hazard or exception handling sit outside this block.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next edge leaves `nxt_pc_q` at `RESET_PC` (default 0), `link_wr_q` at 0 and `link_val_q` at 0.
- R2: Every output is registered. The values that `pc_i`, `instr_i`, `ops_equal_i` and `rs_val_i` carry at a rising edge appear on the outputs just after that edge. An opcode (bits 31..26) other than 0, 2, 3, 4 or 5 selects the following word, `pc + 4`.
- R3: Opcode 4 (branch-if-equal) with `ops_equal_i` = 1 selects `pc + 4 + sext(instr[15:0]) * 4`. With `ops_equal_i` = 0 it selects `pc + 4`.
- R4: Opcode 5 (branch-if-not-equal) with `ops_equal_i` = 0 selects `pc + 4 + sext(instr[15:0]) * 4`. With `ops_equal_i` = 1 it selects `pc + 4`. For example, pc 80012 with offset +2 gives 80024.
- R5: Opcode 2 (jump) selects `{(pc+4)[31:28], instr[25:0], 2'b00}`. For example, field 20000 at pc 80020 gives 80000.
- R6: Opcode 3 (jump-and-link) selects the same target as R5, sets `link_wr_q` to 1 and sets `link_val_q` to `pc + 4`.
- R7: Opcode 0 with function field `instr[5:0]` = 8 (jump-register) selects `rs_val_i` with its two low bits cleared. Opcode 0 with any other function field selects `pc + 4`.
- R8: `link_wr_q` is 1 only for jump-and-link. For every other instruction it is 0 and `link_val_q` is 0.
- R9: The two low bits of `nxt_pc_q` are always 0. The two low bits of `pc_i` have no effect on any output.
- R10: Address arithmetic wraps modulo 2^32. A negative offset moves the branch target backward, and pc 0xFFFFFFFC advances to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc_i | input | 32 | Byte address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| ops_equal_i | input | 1 | High when the two register operands are equal |
| rs_val_i | input | 32 | Contents of the source register |
| nxt_pc_q | output | 32 | Registered next fetch address |
| link_val_q | output | 32 | Registered return address for the call instruction |
| link_wr_q | output | 1 | Registered write strobe for register 31 |

## Verification
The directed sequence applies both branch opcodes with the equality flag set and with it clear, so a swapped taken condition shows up as a wrong target. Forward, backward and wrapping offsets check the sign extension and the scaling by four. Jumps run from program counters whose top nibble differs, which catches a region taken from the wrong address. The jump-register case uses a misaligned register value, and a non-jump R-type is included to show that the function field is decoded. A long run of random instruction words, program counters and flags is then checked every clock against a behavioural model in the bench.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
  localparam logic [OPC_W-1:0] OPC_JUMP    = 6'd2;
  localparam logic [OPC_W-1:0] OPC_CALL    = 6'd3;
  localparam logic [OPC_W-1:0] OPC_BR_EQ   = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BR_NE   = 6'd5;
  localparam logic [FN_W-1:0]  FN_REGJUMP  = 6'd8;

  typedef enum logic [1:0] {
    SEL_SEQ = 2'd0,
    SEL_BR  = 2'd1,
    SEL_JMP = 2'd2,
    SEL_REG = 2'd3
  } npc_sel_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [31:0] instr_i,
  input  logic        ops_equal_i,
  output npc_sel_e    sel_o,
  output logic        link_o
);
  logic [OPC_W-1:0] opc;
  logic [FN_W-1:0]  fn;

  assign opc = instr_i[31:26];
  assign fn  = instr_i[FN_W-1:0];

  always_comb begin
    sel_o  = SEL_SEQ;
    link_o = 1'b0;
    unique case (opc)
      OPC_BR_EQ:   if (ops_equal_i)  sel_o = SEL_BR;
      OPC_BR_NE:   if (!ops_equal_i) sel_o = SEL_BR;
      OPC_JUMP:    sel_o = SEL_JMP;
      OPC_CALL: begin
        sel_o  = SEL_JMP;
        link_o = 1'b1;
      end
      OPC_SPECIAL: if (fn == FN_REGJUMP) sel_o = SEL_REG;
      default:     sel_o = SEL_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int ADDR_W    = 32,
  parameter int ALIGN_W   = 2,
  parameter int OFF_W     = 16,
  parameter int JIDX_W    = 26
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [31:0]       instr_i,
  input  logic [ADDR_W-1:0] rs_val_i,
  output logic [ADDR_W-1:0] seq_o,
  output logic [ADDR_W-1:0] br_o,
  output logic [ADDR_W-1:0] jmp_o,
  output logic [ADDR_W-1:0] reg_o
);
  localparam int WORD_BYTES = 1 << ALIGN_W;
  localparam int SEXT_W     = ADDR_W - OFF_W - ALIGN_W;
  localparam int REGION_LO  = JIDX_W + ALIGN_W;

  logic [ADDR_W-1:0] pc_al;
  logic [ADDR_W-1:0] off_bytes;
  logic [OFF_W-1:0]  off_f;

  assign pc_al     = {pc_i[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
  assign off_f     = instr_i[OFF_W-1:0];
  assign off_bytes = {{SEXT_W{off_f[OFF_W-1]}}, off_f, {ALIGN_W{1'b0}}};

  assign seq_o = pc_al + ADDR_W'(WORD_BYTES);
  assign br_o  = seq_o + off_bytes;
  assign reg_o = {rs_val_i[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};

  generate
    if (ADDR_W > REGION_LO) begin : g_region
      assign jmp_o = {seq_o[ADDR_W-1:REGION_LO], instr_i[JIDX_W-1:0], {ALIGN_W{1'b0}}};
    end else begin : g_flat
      assign jmp_o = ADDR_W'({instr_i[JIDX_W-1:0], {ALIGN_W{1'b0}}});
    end
  endgenerate
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [31:0]       instr_i,
  input  logic              ops_equal_i,
  input  logic [ADDR_W-1:0] rs_val_i,
  output logic [ADDR_W-1:0] nxt_pc_q,
  output logic [ADDR_W-1:0] link_val_q,
  output logic              link_wr_q
);
  import npc_pkg::*;

  npc_sel_e          sel;
  logic              link;
  logic [ADDR_W-1:0] t_seq, t_br, t_jmp, t_reg;
  logic [ADDR_W-1:0] nxt_d;

  npc_decode u_dec (
    .instr_i     (instr_i),
    .ops_equal_i (ops_equal_i),
    .sel_o       (sel),
    .link_o      (link)
  );

  npc_target #(.ADDR_W(ADDR_W)) u_tgt (
    .pc_i     (pc_i),
    .instr_i  (instr_i),
    .rs_val_i (rs_val_i),
    .seq_o    (t_seq),
    .br_o     (t_br),
    .jmp_o    (t_jmp),
    .reg_o    (t_reg)
  );

  always_comb begin
    unique case (sel)
      SEL_BR:  nxt_d = t_br;
      SEL_JMP: nxt_d = t_jmp;
      SEL_REG: nxt_d = t_reg;
      default: nxt_d = t_seq;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_pc_q   <= ADDR_W'(RESET_PC);
      link_val_q <= '0;
      link_wr_q  <= 1'b0;
    end else begin
      nxt_pc_q   <= nxt_d;
      link_val_q <= link ? t_seq : '0;
      link_wr_q  <= link;
    end
  end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] pc_i,
  input logic [31:0]       instr_i,
  input logic [ADDR_W-1:0] nxt_pc_q,
  input logic [ADDR_W-1:0] link_val_q,
  input logic              link_wr_q
);
  logic [5:0]        opc;
  logic [ADDR_W-1:0] pc_next_word;
  assign opc          = instr_i[31:26];
  assign pc_next_word = {pc_i[ADDR_W-1:2], 2'b00} + ADDR_W'(4);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (nxt_pc_q == ADDR_W'(RESET_PC) && !link_wr_q && link_val_q == '0)); // R1

  AST_PLAIN_SEQ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opc) > 6'd5) |-> nxt_pc_q == $past(pc_next_word)); // R2

  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opc) == 6'd2) |->
      (nxt_pc_q[ADDR_W-1:28] == $past(pc_next_word[ADDR_W-1:28]) &&
       nxt_pc_q[27:2] == $past(instr_i[25:0]))); // R5

  AST_CALL_LINK: assert property (@(posedge clk) disable iff (rst)
    link_wr_q |-> link_val_q == $past(pc_next_word)); // R6

  AST_LINK_ONLY_CALL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && link_wr_q) |-> $past(opc) == 6'd3); // R8

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    nxt_pc_q[1:0] == 2'b00); // R9
endmodule

bind npc_unit npc_unit_chk #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pc_i       (pc_i),
  .instr_i    (instr_i),
  .nxt_pc_q   (nxt_pc_q),
  .link_val_q (link_val_q),
  .link_wr_q  (link_wr_q)
);

// File: tb/npc_unit_bench.sv
`timescale 1ns/1ps
module npc_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] pc, instr, rs_val;
  logic        eq;
  logic [31:0] nxt_pc_q, link_val_q;
  logic        link_wr_q;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  npc_unit u_npc_unit (
    .clk (clk), .rst (rst), .pc_i (pc), .instr_i (instr),
    .ops_equal_i (eq), .rs_val_i (rs_val),
    .nxt_pc_q (nxt_pc_q), .link_val_q (link_val_q), .link_wr_q (link_wr_q)
  );

  function automatic string tag_of(logic [31:0] ins);
    int op = int'(ins[31:26]);
    if (op == 4) return "R3";
    if (op == 5) return "R4";
    if (op == 2) return "R5";
    if (op == 3) return "R6";
    if (op == 0) return "R7";
    return "R2";
  endfunction

  task automatic compare(string tag, logic [31:0] e_pc, logic [31:0] e_lv, logic e_lw);
    checks++;
    if (nxt_pc_q !== e_pc || link_val_q !== e_lv || link_wr_q !== e_lw) begin
      errors++;
      $display("FAIL %s: pc=%h lv=%h lw=%b expected pc=%h lv=%h lw=%b",
               tag, nxt_pc_q, link_val_q, link_wr_q, e_pc, e_lv, e_lw);
    end
    if (nxt_pc_q[1:0] !== 2'b00) begin  // R9
      errors++;
      $display("FAIL R9: low bits %b expected 00", nxt_pc_q[1:0]);
    end
  endtask

  // Behavioural reference: one instruction in, expected outputs one edge later.
  task automatic step(logic [31:0] p, logic [31:0] ins, logic e, logic [31:0] r, string tag = "");
    longint unsigned base, follow, tgt;
    int op, off;
    logic [31:0] e_pc, e_lv;
    logic e_lw;
    pc = p; instr = ins; eq = e; rs_val = r;
    base   = longint'(p) & 64'hFFFF_FFFC;
    follow = (base + 4) % 64'h1_0000_0000;
    op     = int'(ins[31:26]);
    off    = int'($signed(ins[15:0]));
    e_pc = follow[31:0]; e_lv = 32'h0; e_lw = 1'b0;
    if ((op == 4 && e) || (op == 5 && !e)) begin
      tgt = (follow + longint'(off) * 4) % 64'h1_0000_0000;
      e_pc = tgt[31:0];
    end else if (op == 2 || op == 3) begin
      e_pc = (follow[31:0] & 32'hF000_0000) | (32'(ins[25:0]) * 4);
      if (op == 3) begin e_lv = follow[31:0]; e_lw = 1'b1; end
    end else if (op == 0 && ins[5:0] == 6'd8) begin
      e_pc = r & 32'hFFFF_FFFC;
    end
    @(negedge clk);
    compare(tag == "" ? tag_of(ins) : tag, e_pc, e_lv, e_lw);
  endtask

  function automatic logic [31:0] itype(int op, int off);
    return {6'(op), 5'd8, 5'd21, 16'(off)};
  endfunction

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pc = 32'h0000_1234; instr = {6'd2, 26'h3FF_FFFF}; eq = 1'b0; rs_val = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    compare("R1", 32'h0, 32'h0, 1'b0);
    rst = 1'b0;

    step(32'd80012, itype(5, 2), 1'b0, 32'h0);                 // R4 taken -> 80024
    step(32'd80012, itype(5, 2), 1'b1, 32'h0);                 // R4 not taken
    step(32'd80012, itype(4, 2), 1'b1, 32'h0);                 // R3 taken
    step(32'd80012, itype(4, 2), 1'b0, 32'h0);                 // R3 not taken
    step(32'h0000_1000, itype(4, -3), 1'b1, 32'h0);            // R3 backward
    step(32'h0000_0004, itype(5, -4), 1'b0, 32'h0, "R10");     // wraps below zero
    step(32'hFFFF_FFFC, 32'h8C00_0000, 1'b0, 32'h0, "R10");    // sequential wrap
    step(32'd80020, {6'd2, 26'd20000}, 1'b0, 32'h0);           // R5 -> 80000
    step(32'hA000_0100, {6'd2, 26'h123_4567}, 1'b1, 32'h0);    // R5 upper region
    step(32'hEFFF_FFFC, {6'd2, 26'h000_0010}, 1'b0, 32'h0);    // R5 region of pc+4
    step(32'h3000_0040, {6'd3, 26'h00A_BCDE}, 1'b0, 32'h0);    // R6 call
    step(32'h3000_0040, 32'h0000_0020, 1'b1, 32'h7777_7777, "R8"); // link cleared
    step(32'h0000_2000, {6'd0, 5'd31, 15'd0, 6'd8}, 1'b0, 32'h1234_5677); // R7
    step(32'h0000_2000, {6'd0, 5'd31, 15'd0, 6'd9}, 1'b0, 32'h1234_5677); // R7 other funct
    step(32'h0000_2003, 32'h2108_0001, 1'b0, 32'h0, "R9");     // misaligned pc ignored
    step(32'd80015, itype(5, 2), 1'b0, 32'h0, "R9");
    step(32'h0000_0400, {6'd35, 26'h0}, 1'b1, 32'h0);          // R2 load

    rst = 1'b1;
    @(negedge clk);
    compare("R1", 32'h0, 32'h0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < 2000; i++) begin
      logic [31:0] ins = $urandom;
      if (i % 3 == 0) ins[31:26] = 6'($urandom_range(0, 5));
      if (ins[31:26] == 6'd0 && i % 2 == 0) ins[5:0] = 6'd8;
      step($urandom, ins, 1'($urandom), $urandom);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule